// File: doc/BRIEF.md
# DMA Debug Status and Selectable Status Viewer

This block holds the debug state of a DMA engine that runs up to 16 tasks, and it gives a register bus a view of that state. It keeps two kinds of sticky flag. The first is one triggered flag, set when the engine reports a breakpoint. The second is a set of per-task blocked flags, one per task, each set when a breakpoint halts that task. Software clears any of these flags by writing a one to its bit. Writing a zero to a bit leaves it as it is.

A second address is an indirect viewing window. A write to it stores a selector code, and that code stays in force until the next write. Each read of the same address returns the read-only status vector the code selects:

| Selector | Vector returned |
|---|---|
| 0 | The raw initiator request lines |
| 1 | Each task's valid bit ANDed with the request line of the initiator assigned to that task |
| 2 | The task valid bits |
| 3 | The task hold bits |

Reads have no side effects. A small access state machine tracks the response phase:

- `ACC_IDLE`: no response is due. `bus_rdata` is zero.
- `ACC_RD_STATUS`: the cycle after a status read. The captured flags are driven.
- `ACC_RD_WINDOW`: the cycle after a window read. The captured view is driven.
- `ACC_RD_NONE`: the cycle after a read of an unmapped address. Zero is driven.

Every cycle, the state machine steps from its current state to the state that matches the access in that cycle. A read strobe selects `ACC_RD_STATUS`, `ACC_RD_WINDOW` or `ACC_RD_NONE` by address. A write, or no strobe, selects `ACC_IDLE`.

Top module: `dma_dbg_view`

## Requirements
- R1: After reset, all sticky flags and the selector are zero, and `bus_rdata` is zero.
- R2: The access is a read of status address 0x00 when `bus_valid` is 1 and `bus_we` is 0. In the cycle after such a read, `bus_rdata` returns the triggered flag at bit 16 and the blocked flags at bits 15..0, with bits 31..17 zero. In any cycle that does not follow a read strobe, `bus_rdata` is zero.
- R3: A cycle with `bp_trig` high sets the triggered flag from the next cycle on. The flag then stays set until it is cleared.
- R4: A write to address 0x00 with bit 16 of the data at 1 clears the triggered flag. The same write with bit 16 at 0 leaves the flag unchanged.
- R5: A cycle with `bp_block[t]` high sets blocked flag t. A write to 0x00 with data bit t at 1 clears that flag, and a 0 in bit t leaves it unchanged.
- R6: When a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R7: A write to window address 0x04 stores data bits 7..0 as the selector. The selector holds until the next such write. Reads never change the selector or any flag.
- R8: With selector 0, a window read returns `init_req` in bits 30..0, and bit 31 is 0.
- R9: With selector 1, bit t of a window read is `task_valid[t]` AND `init_req[id]`, where id is `task_init_id[5t+4:5t]`. An id of 31 names no initiator, so the bit reads 0.
- R10: With selector 2, a window read returns `task_valid`. With selector 3, it returns `task_hold`. In both cases bits 31..16 are zero.
- R11: Any selector value from 4 to 255 makes a window read return zero.
- R12: A read of any address other than 0x00 or 0x04 returns zero. A write to such an address changes no flag and does not change the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read strobe |
| init_req | input | 31 | Raw initiator request lines |
| task_valid | input | 16 | Per-task valid bits |
| task_init_id | input | 80 | Five-bit initiator id per task, task t at bits 5t+4..5t |
| task_hold | input | 16 | Per-task hold bits |
| bp_trig | input | 1 | Breakpoint-triggered event |
| bp_block | input | 16 | Per-task breakpoint-blocked events |

## Verification
The assertions check the following on every cycle:

- The sticky flags set, hold and clear as required, with the set winning over a same-cycle clear.
- The selector changes only on a window write.
- A status read echoes the flags one cycle later.
- `bus_rdata` is zero whenever no read response is due.

The bench's scenarios are the only way to show that each window selector returns the correct vector. This covers the per-task initiator lookup, including the id that names no initiator, and the zero result for out-of-range selectors. The scenarios also show that a selector persists across reads and that accesses to unmapped addresses have no effect.

// File: rtl/dma_dbg_pkg.sv
package dma_dbg_pkg;

    // Response phase of the register bus
    typedef enum logic [1:0] {
        ACC_IDLE      = 2'd0,
        ACC_RD_STATUS = 2'd1,
        ACC_RD_WINDOW = 2'd2,
        ACC_RD_NONE   = 2'd3
    } acc_e;

    // Window selector codes
    localparam int unsigned SEL_REQ      = 0;
    localparam int unsigned SEL_TASK_REQ = 1;
    localparam int unsigned SEL_VALID    = 2;
    localparam int unsigned SEL_HOLD     = 3;

endpackage

// File: rtl/dma_dbg_sticky.sv
module dma_dbg_sticky #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // One flag per bit; a set in the same cycle overrides a clear
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_i[b])
                flag_q <= 1'b1;
            else if (clr_i[b])
                flag_q <= 1'b0;
        end
        assign q_o[b] = flag_q;
    end
endmodule

// File: rtl/dma_dbg_window.sv
module dma_dbg_window
    import dma_dbg_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    parameter int NUM_INIT  = 31,
    parameter int DATA_W    = 32,
    parameter int SEL_W     = 8,
    parameter int ID_W      = $clog2(NUM_INIT + 1)
) (
    input  logic [SEL_W-1:0]          sel_i,
    input  logic [NUM_INIT-1:0]       init_req_i,
    input  logic [NUM_TASKS-1:0]      task_valid_i,
    input  logic [NUM_TASKS*ID_W-1:0] task_init_id_i,
    input  logic [NUM_TASKS-1:0]      task_hold_i,
    output logic [DATA_W-1:0]         view_o
);
    localparam int REQ_PAD_W = 1 << ID_W;

    logic [REQ_PAD_W-1:0] req_pad;
    logic [NUM_TASKS-1:0] task_req;

    // Ids beyond the last initiator index land in the zero padding
    always_comb begin
        req_pad = '0;
        req_pad[NUM_INIT-1:0] = init_req_i;
    end

    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
        logic [ID_W-1:0] id;
        assign id          = task_init_id_i[t*ID_W +: ID_W];
        assign task_req[t] = task_valid_i[t] & req_pad[id];
    end

    always_comb begin
        view_o = '0;
        case (sel_i)
            SEL_W'(SEL_REQ):      view_o[NUM_INIT-1:0]  = init_req_i;
            SEL_W'(SEL_TASK_REQ): view_o[NUM_TASKS-1:0] = task_req;
            SEL_W'(SEL_VALID):    view_o[NUM_TASKS-1:0] = task_valid_i;
            SEL_W'(SEL_HOLD):     view_o[NUM_TASKS-1:0] = task_hold_i;
            default:              view_o = '0;
        endcase
    end
endmodule

// File: rtl/dma_dbg_view.sv
module dma_dbg_view
    import dma_dbg_pkg::*;
#(
    parameter int NUM_TASKS   = 16,
    parameter int NUM_INIT    = 31,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SEL_W       = 8,
    parameter int STATUS_ADDR = 'h00,
    parameter int WINDOW_ADDR = 'h04,
    parameter int ID_W        = $clog2(NUM_INIT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_INIT-1:0]       init_req,
    input  logic [NUM_TASKS-1:0]      task_valid,
    input  logic [NUM_TASKS*ID_W-1:0] task_init_id,
    input  logic [NUM_TASKS-1:0]      task_hold,
    input  logic                      bp_trig,
    input  logic [NUM_TASKS-1:0]      bp_block
);
    localparam int FLAG_W = NUM_TASKS + 1;

    logic                 hit_status, hit_window;
    logic                 wr_status, wr_window, rd_strobe;
    logic [FLAG_W-1:0]    flag_set, flag_clr, flags;
    logic                 trig_q;
    logic [NUM_TASKS-1:0] blk_q;
    logic [SEL_W-1:0]     sel_q;
    logic [DATA_W-1:0]    view, status_word, snap_q;
    acc_e                 acc_q, acc_d;

    // Address decode
    assign hit_status = (bus_addr == ADDR_W'(STATUS_ADDR));
    assign hit_window = (bus_addr == ADDR_W'(WINDOW_ADDR));
    assign wr_status  = bus_valid &  bus_we & hit_status;
    assign wr_window  = bus_valid &  bus_we & hit_window;
    assign rd_strobe  = bus_valid & ~bus_we;

    // Sticky flags: blocked bits in the low positions, triggered on top
    assign flag_set = {bp_trig, bp_block};
    assign flag_clr = wr_status ? bus_wdata[FLAG_W-1:0] : '0;

    dma_dbg_sticky #(.W(FLAG_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flags)
    );

    assign trig_q = flags[NUM_TASKS];
    assign blk_q  = flags[NUM_TASKS-1:0];

    always_comb begin
        status_word = '0;
        status_word[FLAG_W-1:0] = flags;
    end

    // Window selector
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_window)
            sel_q <= bus_wdata[SEL_W-1:0];
    end

    dma_dbg_window #(
        .NUM_TASKS (NUM_TASKS),
        .NUM_INIT  (NUM_INIT),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .ID_W      (ID_W)
    ) u_window (
        .sel_i          (sel_q),
        .init_req_i     (init_req),
        .task_valid_i   (task_valid),
        .task_init_id_i (task_init_id),
        .task_hold_i    (task_hold),
        .view_o         (view)
    );

    // Access state machine: next state
    always_comb begin
        acc_d = ACC_IDLE;
        if (rd_strobe) begin
            if (hit_status)
                acc_d = ACC_RD_STATUS;
            else if (hit_window)
                acc_d = ACC_RD_WINDOW;
            else
                acc_d = ACC_RD_NONE;
        end
    end

    // State register and read snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_IDLE;
            snap_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (rd_strobe)
                snap_q <= hit_status ? status_word : view;
        end
    end

    // Outputs per state
    always_comb begin
        unique case (acc_q)
            ACC_IDLE:      bus_rdata = '0;
            ACC_RD_STATUS: bus_rdata = snap_q;
            ACC_RD_WINDOW: bus_rdata = snap_q;
            ACC_RD_NONE:   bus_rdata = '0;
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_dbg_view_chk.sv
module dma_dbg_view_chk #(
    parameter int NUM_TASKS   = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SEL_W       = 8,
    parameter int STATUS_ADDR = 'h00,
    parameter int WINDOW_ADDR = 'h04
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 bp_trig,
    input logic [NUM_TASKS-1:0] bp_block,
    input logic                 trig_q,
    input logic [NUM_TASKS-1:0] blk_q,
    input logic [SEL_W-1:0]     sel_q
);
    logic wr_st, wr_win, rd_st;
    assign wr_st  = bus_valid && bus_we && bus_addr == ADDR_W'(STATUS_ADDR);
    assign wr_win = bus_valid && bus_we && bus_addr == ADDR_W'(WINDOW_ADDR);
    assign rd_st  = bus_valid && !bus_we && bus_addr == ADDR_W'(STATUS_ADDR);

    AST_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bp_trig |=> trig_q); // R3

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && !(wr_st && bus_wdata[NUM_TASKS])) |=> trig_q); // R4

    AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && bus_wdata[NUM_TASKS] && !bp_trig) |=> !trig_q); // R4

    AST_BLOCK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|bp_block) |=> ((blk_q & $past(bp_block)) == $past(bp_block))); // R6

    AST_BLOCK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_block == '0) |=> ((blk_q & ~$past(blk_q)) == '0)); // R5

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_win |=> $stable(sel_q)); // R7

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> (bus_rdata == '0)); // R2

    AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> (bus_rdata == DATA_W'({$past(trig_q), $past(blk_q)}))); // R2
endmodule

bind dma_dbg_view dma_dbg_view_chk #(
    .NUM_TASKS   (NUM_TASKS),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SEL_W       (SEL_W),
    .STATUS_ADDR (STATUS_ADDR),
    .WINDOW_ADDR (WINDOW_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bp_trig   (bp_trig),
    .bp_block  (bp_block),
    .trig_q    (trig_q),
    .blk_q     (blk_q),
    .sel_q     (sel_q)
);

// File: tb/test_dma_dbg_view.sv
`timescale 1ns/1ps
module test_dma_dbg_view;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [30:0] init_req = '0;
    logic [15:0] task_valid = '0;
    logic [79:0] task_init_id = '0;
    logic [15:0] task_hold = '0;
    logic        bp_trig = 1'b0;
    logic [15:0] bp_block = '0;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_dbg_view i_dma_dbg_view (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .init_req     (init_req),
        .task_valid   (task_valid),
        .task_init_id (task_init_id),
        .task_hold    (task_hold),
        .bp_trig      (bp_trig),
        .bp_block     (bp_block)
    );

    typedef struct packed {
        logic [7:0]  sel;
        logic [30:0] req;
        logic [15:0] vld;
        logic [15:0] hld;
        logic [31:0] exp;
    } vec_t;

    // Task t is mapped to initiator 2t
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   31'h1234_5678, 16'h0000, 16'h0000, 32'h1234_5678},
        '{8'd0,   31'h7FFF_FFFF, 16'hFFFF, 16'hFFFF, 32'h7FFF_FFFF},
        '{8'd2,   31'h0000_0000, 16'hA5C3, 16'h1111, 32'h0000_A5C3},
        '{8'd3,   31'h7FFF_FFFF, 16'hFFFF, 16'h0F0F, 32'h0000_0F0F},
        '{8'd1,   31'h7FFF_FFFF, 16'hBEEF, 16'h0000, 32'h0000_BEEF},
        '{8'd1,   31'h5555_5555, 16'hFFFF, 16'h0000, 32'h0000_FFFF},
        '{8'd1,   31'h2AAA_AAAA, 16'hFFFF, 16'h0000, 32'h0000_0000},
        '{8'd1,   31'h0000_0005, 16'h0002, 16'h0000, 32'h0000_0002},
        '{8'd4,   31'h7FFF_FFFF, 16'hFFFF, 16'hFFFF, 32'h0000_0000},
        '{8'hFF,  31'h7FFF_FFFF, 16'hFFFF, 16'hFFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic trig, input logic [15:0] blk);
        @(negedge clk);
        bp_trig = trig; bp_block = blk;
        @(negedge clk);
        bp_trig = 1'b0; bp_block = '0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int t = 0; t < 16; t++) task_init_id[t*5 +: 5] = 5'(2 * t);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rdata idle", bus_rdata, 32'h0);
        bus_read(8'h00, rd);
        check("R1 status", rd, 32'h0);
        init_req = 31'h0ABC_DEF1;
        bus_read(8'h04, rd);
        check("R1 selector zero", rd, 32'h0ABC_DEF1);

        // Window vector table: R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            init_req   = VECS[i].req;
            task_valid = VECS[i].vld;
            task_hold  = VECS[i].hld;
            bus_write(8'h04, {24'hC3A5_96, VECS[i].sel});
            bus_read(8'h04, rd);
            check("R8/R9/R10/R11 window", rd, VECS[i].exp);
            bus_read(8'h04, rd);
            check("R7 selector persists", rd, VECS[i].exp);
        end

        // R9: id 31 names no initiator
        task_init_id[4:0] = 5'd31;
        init_req = 31'h7FFF_FFFF; task_valid = 16'hFFFF;
        bus_write(8'h04, 32'h1);
        bus_read(8'h04, rd);
        check("R9 id 31", rd, 32'h0000_FFFE);
        task_init_id[4:0] = 5'd0;

        // R3 set and hold
        pulse(1'b1, 16'h0);
        repeat (3) @(negedge clk);
        bus_read(8'h00, rd);
        check("R3 trig sticky", rd, 32'h0001_0000);
        // R4 write 0 no effect, write 1 clears
        bus_write(8'h00, 32'hFFFE_FFFF & 32'h0000_FFFF);
        bus_read(8'h00, rd);
        check("R4 write zero keeps", rd, 32'h0001_0000);
        bus_write(8'h00, 32'h0001_0000);
        bus_read(8'h00, rd);
        check("R4 write one clears", rd, 32'h0);

        // R5 blocked flags
        pulse(1'b0, 16'h8001);
        pulse(1'b0, 16'h0100);
        bus_read(8'h00, rd);
        check("R5 blocked set", rd, 32'h0000_8101);
        bus_write(8'h00, 32'h0000_0001);
        bus_read(8'h00, rd);
        check("R5 blocked w1c", rd, 32'h0000_8100);

        // R7 window reads leave flags alone
        bus_write(8'h04, 32'h2);
        bus_read(8'h04, rd);
        bus_read(8'h04, rd);
        bus_read(8'h00, rd);
        check("R7 read no side effect", rd, 32'h0000_8100);

        // R6 set wins over clear
        @(negedge clk);
        bp_trig = 1'b1; bp_block = 16'h0008;
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_8108;
        @(negedge clk);
        bp_trig = 1'b0; bp_block = '0;
        bus_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        bus_read(8'h00, rd);
        check("R6 set wins", rd, 32'h0001_0008);

        // R12 unmapped addresses
        bus_read(8'h08, rd);
        check("R12 unmapped read", rd, 32'h0);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'h0000_0003);
        bus_read(8'h00, rd);
        check("R12 unmapped write flags", rd, 32'h0001_0008);
        task_valid = 16'h1234; task_hold = 16'h4321;
        bus_read(8'h04, rd);
        check("R12 unmapped write selector", rd, 32'h0000_1234);

        // R2 rdata zero when no read is pending
        @(negedge clk);
        check("R2 idle rdata", bus_rdata, 32'h0);

        // R1 reset clears again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(8'h00, rd);
        check("R1 reset clears flags", rd, 32'h0);
        init_req = 31'h0000_0077;
        bus_read(8'h04, rd);
        check("R1 reset clears selector", rd, 32'h0000_0077);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule